// File: doc/BRIEF.md
# LCD Frame Timing Generator

This block produces the scan timing for a dot-matrix LCD row driver that runs as the timing master. It divides a system clock into a line clock and counts lines into frames. It emits a first-line marker once per frame and an alternating polarity signal for the drive waveform. It also drives an enable output that turns the display on only once the panel has been scanned a few times after reset.

Static inputs set the frame length (120 or 240 lines) and the number of lines between polarity flips. A further input selects whether the polarity signal is also XORed with a waveform that flips once per frame. An active-low blanking input can switch the display off at any time. The outputs go to the column drivers and to the row shift register of the panel.

Top module: `lcd_frame_timing`

## Requirements
- R1: `line_clk` is low during reset, goes high on the first clock edge after reset is released, and then toggles on every edge (period 2 clocks, 50% duty).
- R2: With `long_frame` low a frame is 120 lines (240 clocks); with it high a frame is 240 lines (480 clocks).
- R3: `frame_mark` is high for exactly one `line_clk` period (2 clocks) at the first line of every frame. The first pulse starts at the second edge after reset release.
- R4: With `inv_lines` = N in 10..63 and `frame_xor_en` low, `alt_out` flips every N lines, first at edge 2N after reset release.
- R5: With `inv_lines` = 0 the line alternation is disabled and, with `frame_xor_en` low, `alt_out` stays low.
- R6: An `inv_lines` value from 1 to 9 behaves exactly like 10.
- R7: With `frame_xor_en` high, `alt_out` is the line alternation XOR a frame waveform that starts low and flips at the start of every frame, including the first.
- R8: The line-alternation count runs on across frame boundaries and is cleared only by reset, so an N that does not divide the frame length drifts in phase from frame to frame.
- R9: Reset is synchronous and active-low. It clears all counters and forces `line_clk`, `frame_mark`, `alt_out` and `disp_en` low on the next edge.
- R10: `disp_en` stays low after reset until the fourth frame start, and rises on the same edge as the fourth `frame_mark` pulse.
- R11: While `blank_n` is low, `disp_en` is low from the next edge on. It returns high on the edge after `blank_n` rises, provided the hold-off is over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| long_frame | input | 1 | 0: 120-line frame, 1: 240-line frame |
| inv_lines | input | 6 | Lines between polarity flips (0 disables, 1..9 act as 10) |
| frame_xor_en | input | 1 | XOR polarity with a per-frame toggle |
| blank_n | input | 1 | Active-low display blank request |
| line_clk | output | 1 | Line transfer clock, half the system clock rate |
| frame_mark | output | 1 | First-line marker, one line long |
| alt_out | output | 1 | Alternating polarity signal |
| disp_en | output | 1 | Display enable control |

## Verification
The hardest state to reach is the end of the post-reset hold-off. It appears only after four full frames, up to 1442 clocks in the long-frame setting. The polarity-phase drift across frames is just as slow to show. The stimulus therefore runs each configuration for several complete frames and compares every output on every cycle against a closed-form model indexed by the edge count since release. Blanking is applied both after the hold-off and during it, and a second reset is applied mid-run, so each case starts from a known position.

// File: rtl/lcdt_pkg.sv
// Shared definitions for the LCD frame timing generator.
// Assumes: one clock domain, all configuration inputs static outside reset.
package lcdt_pkg;
    // Per-line events passed from the line counter to its consumers.
    typedef struct packed {
        logic line_tick;    // line boundary: line_clk falls on this edge
        logic frame_start;  // line boundary that wraps the frame to line 0
    } lcdt_evt_t;
endpackage

// File: rtl/lcdt_clkdiv.sv
// Divides the system clock by two to form the line clock.
// Assumes: synchronous active-low reset; line_tick marks the edge on which
// line_clk falls, which is where a new line begins.
module lcdt_clkdiv (
    input  logic clk,
    input  logic rst_n,
    output logic line_clk,
    output logic line_tick
);
    logic phase_q;
    logic run_q;

    // Toggle the phase every edge; low while in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= 1'b0;
        else        phase_q <= ~phase_q;
    end

    // Remember that the previous edge was already out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= 1'b1;
    end

    assign line_clk  = phase_q;
    assign line_tick = phase_q;

    // R1: line clock alternates on every edge once running
    a_r1_line_clk_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (line_clk != $past(line_clk)));
endmodule

// File: rtl/lcdt_line_ctr.sv
// Counts lines within a frame and forms the first-line marker.
// Assumes: long_frame is static outside reset. The counter resets to the last
// line so that the first line boundary after reset opens frame 0.
module lcdt_line_ctr #(
    parameter int SHORT_LINES = 120,
    parameter int LONG_LINES  = 240,
    parameter int LINE_W      = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                long_frame,
    input  logic                line_tick,
    output lcdt_pkg::lcdt_evt_t evt,
    output logic                frame_mark
);
    logic [LINE_W-1:0] line_idx;
    logic [LINE_W-1:0] last_line;
    logic              wrap;

    // Last line index for the selected frame length.
    always_comb begin
        last_line = long_frame ? LINE_W'(LONG_LINES - 1) : LINE_W'(SHORT_LINES - 1);
        wrap      = (line_idx >= last_line);
    end

    // Advance the line index on each line boundary, wrapping at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n)         line_idx <= last_line;
        else if (line_tick) line_idx <= wrap ? '0 : line_idx + 1'b1;
    end

    // Hold the marker high for the whole of line 0.
    always_ff @(posedge clk) begin
        if (!rst_n)         frame_mark <= 1'b0;
        else if (line_tick) frame_mark <= wrap;
    end

    assign evt.line_tick   = line_tick;
    assign evt.frame_start = line_tick & wrap;

    // R3: the marker is only ever seen on line 0
    a_r3_mark_on_line0: assert property (@(posedge clk) disable iff (!rst_n)
        frame_mark |-> (line_idx == '0));
    // R2: the line index stays inside the selected frame
    a_r2_index_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        line_idx <= last_line);
endmodule

// File: rtl/lcdt_alt_gen.sv
// Builds the alternating polarity signal from a free-running line count and
// an optional per-frame toggle.
// Assumes: inv_lines static outside reset; 0 disables line alternation and
// values below INV_MIN are raised to INV_MIN.
module lcdt_alt_gen #(
    parameter int INV_W   = 6,
    parameter int INV_MIN = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  lcdt_pkg::lcdt_evt_t evt,
    input  logic [INV_W-1:0]    inv_lines,
    input  logic                frame_xor_en,
    output logic                alt_out
);
    logic [INV_W-1:0] n_eff;
    logic [INV_W-1:0] alt_cnt;
    logic             line_alt;
    logic             frame_alt;
    logic             at_end;

    // Effective inversion period after clamping small values.
    always_comb begin
        if (inv_lines == '0)                  n_eff = '0;
        else if (inv_lines < INV_W'(INV_MIN)) n_eff = INV_W'(INV_MIN);
        else                                  n_eff = inv_lines;
        at_end = (n_eff != '0) && (alt_cnt >= n_eff - 1'b1);
    end

    // Count lines across frame boundaries; flip the line waveform at the period end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alt_cnt  <= '0;
            line_alt <= 1'b0;
        end else if (evt.line_tick && n_eff != '0) begin
            alt_cnt  <= at_end ? '0 : alt_cnt + 1'b1;
            line_alt <= line_alt ^ at_end;
        end
    end

    // Flip the frame waveform at every frame start.
    always_ff @(posedge clk) begin
        if (!rst_n)               frame_alt <= 1'b0;
        else if (evt.frame_start) frame_alt <= ~frame_alt;
    end

    assign alt_out = line_alt ^ (frame_xor_en & frame_alt);

    // R5: with alternation disabled the line waveform never moves
    a_r5_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (n_eff == '0) |=> $stable(line_alt));
    // R4: no flip before the period has elapsed
    a_r4_no_early_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (!at_end) |=> $stable(line_alt));
    // R6: the effective period is never below the minimum
    a_r6_period_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_lines != '0) |-> (n_eff >= INV_W'(INV_MIN)));
endmodule

// File: rtl/lcdt_doc_ctl.sv
// Display enable control: holds the display off for a number of frames after
// reset and whenever blanking is requested.
// Assumes: frame_start pulses once per frame, the first one one line after reset.
module lcdt_doc_ctl #(
    parameter int HOLD_FRAMES = 4,
    parameter int HOLD_W      = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  lcdt_pkg::lcdt_evt_t evt,
    input  logic                blank_n,
    output logic                disp_en
);
    logic [HOLD_W-1:0] hold_cnt;
    logic [HOLD_W-1:0] hold_nx;

    // Next hold-off count, saturating at the target.
    always_comb begin
        hold_nx = hold_cnt;
        if (evt.frame_start && hold_cnt != HOLD_W'(HOLD_FRAMES))
            hold_nx = hold_cnt + 1'b1;
    end

    // Register the frame count since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) hold_cnt <= '0;
        else        hold_cnt <= hold_nx;
    end

    // Enable once the hold-off is over and no blank is requested.
    always_ff @(posedge clk) begin
        if (!rst_n) disp_en <= 1'b0;
        else        disp_en <= blank_n && (hold_nx == HOLD_W'(HOLD_FRAMES));
    end

    // R10: enable only after the full hold-off
    a_r10_holdoff_done: assert property (@(posedge clk) disable iff (!rst_n)
        disp_en |-> (hold_cnt == HOLD_W'(HOLD_FRAMES)));
    // R11: a blank request turns the display off on the next edge
    a_r11_blank_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!blank_n) |=> !disp_en);
endmodule

// File: rtl/lcd_frame_timing.sv
// Top of the LCD frame timing generator (master timing only).
// Assumes: configuration inputs change only while rst_n is low.
module lcd_frame_timing #(
    parameter int SHORT_LINES = 120,
    parameter int LONG_LINES  = 240,
    parameter int INV_W       = 6,
    parameter int INV_MIN     = 10,
    parameter int HOLD_FRAMES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             long_frame,
    input  logic [INV_W-1:0] inv_lines,
    input  logic             frame_xor_en,
    input  logic             blank_n,
    output logic             line_clk,
    output logic             frame_mark,
    output logic             alt_out,
    output logic             disp_en
);
    localparam int LINE_W = $clog2(LONG_LINES);
    localparam int HOLD_W = $clog2(HOLD_FRAMES + 1);

    logic                line_tick;
    lcdt_pkg::lcdt_evt_t evt;

    lcdt_clkdiv u_clkdiv (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_clk  (line_clk),
        .line_tick (line_tick)
    );

    lcdt_line_ctr #(
        .SHORT_LINES (SHORT_LINES),
        .LONG_LINES  (LONG_LINES),
        .LINE_W      (LINE_W)
    ) u_line_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .long_frame (long_frame),
        .line_tick  (line_tick),
        .evt        (evt),
        .frame_mark (frame_mark)
    );

    lcdt_alt_gen #(
        .INV_W   (INV_W),
        .INV_MIN (INV_MIN)
    ) u_alt_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt          (evt),
        .inv_lines    (inv_lines),
        .frame_xor_en (frame_xor_en),
        .alt_out      (alt_out)
    );

    lcdt_doc_ctl #(
        .HOLD_FRAMES (HOLD_FRAMES),
        .HOLD_W      (HOLD_W)
    ) u_doc_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt),
        .blank_n (blank_n),
        .disp_en (disp_en)
    );

    // R9: a reset edge leaves every output low
    a_r9_reset_quiet: assert property (@(posedge clk)
        (!rst_n) |=> (!line_clk && !frame_mark && !alt_out && !disp_en));
endmodule

// File: tb/lcd_frame_timing_tb.sv
module lcd_frame_timing_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       long_frame = 1'b0;
    logic [5:0] inv_lines = 6'd0;
    logic       frame_xor_en = 1'b0;
    logic       blank_n = 1'b1;
    logic       line_clk, frame_mark, alt_out, disp_en;

    int checks = 0;
    int fails  = 0;
    int e      = 0;   // edges since reset release

    always #4 clk = ~clk;   // 125 MHz

    lcd_frame_timing dut_i (
        .clk(clk), .rst_n(rst_n), .long_frame(long_frame), .inv_lines(inv_lines),
        .frame_xor_en(frame_xor_en), .blank_n(blank_n), .line_clk(line_clk),
        .frame_mark(frame_mark), .alt_out(alt_out), .disp_en(disp_en)
    );

    // Vector: {long_frame, inv_lines, frame_xor_en}, each run for RUN_CYC edges.
    localparam int NVEC    = 7;
    localparam int RUN_CYC = 2400;
    localparam logic [7:0] VEC [NVEC] = '{
        {1'b0, 6'd10, 1'b0},   // R4 R2 short frame
        {1'b1, 6'd63, 1'b0},   // R4 R2 long frame, max period
        {1'b0, 6'd0,  1'b0},   // R5 disabled
        {1'b0, 6'd5,  1'b0},   // R6 clamp
        {1'b1, 6'd17, 1'b1},   // R7 R8
        {1'b0, 6'd0,  1'b1},   // R7 frame toggle only
        {1'b0, 6'd37, 1'b0}    // R8 drift across frames
    };

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at edge %0d: actual %b expected %b", tag, e, act, exp);
        end
    endtask

    // Closed-form expectations from edge count e, blank_n assumed high.
    task automatic check_all(input logic blank_ok);
        int L, N, j, fs;
        logic x_clk, x_mark, x_alt, x_en;
        string atag;
        L = long_frame ? 240 : 120;
        N = (inv_lines == 0) ? 0 : ((inv_lines < 10) ? 10 : int'(inv_lines));
        j = e / 2;
        fs = (j >= 1) ? ((j - 1) / L + 1) : 0;
        x_clk  = (e % 2) == 1;
        x_mark = (j >= 1) && (((j - 1) % L) == 0);
        x_alt  = ((N != 0) ? ((j / N) % 2 == 1) : 1'b0) ^ (frame_xor_en && (fs % 2 == 1));
        x_en   = blank_ok && (fs >= 4);
        if (inv_lines == 0 && !frame_xor_en) atag = "R5";
        else if (frame_xor_en)               atag = "R7";
        else if (inv_lines < 10)             atag = "R6";
        else if ((L % N) != 0)               atag = "R8";
        else                                 atag = "R4";
        check("R1 line_clk", line_clk, x_clk);
        check("R3 frame_mark", frame_mark, x_mark);
        check(atag, alt_out, x_alt);
        check("R10 disp_en", disp_en, x_en);
    endtask

    task automatic step(input logic blank_ok);
        @(posedge clk);
        e++;
        @(negedge clk);
        check_all(blank_ok);
    endtask

    // Reset for three edges, check the quiet state (R9), then release.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 line_clk", line_clk, 1'b0);
        check("R9 frame_mark", frame_mark, 1'b0);
        check("R9 alt_out", alt_out, 1'b0);
        check("R9 disp_en", disp_en, 1'b0);
        rst_n = 1'b1;
        e = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // Vector walk: R1 R2 R3 R4 R5 R6 R7 R8 R10.
        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            rst_n = 1'b0;
            {long_frame, inv_lines, frame_xor_en} = VEC[v];
            do_reset();
            for (int c = 0; c < RUN_CYC; c++) step(1'b1);
        end

        // R9: reset in mid-run restarts the sequence from scratch.
        long_frame = 1'b0; inv_lines = 6'd12; frame_xor_en = 1'b1;
        do_reset();
        for (int c = 0; c < 1100; c++) step(1'b1);
        do_reset();
        for (int c = 0; c < 400; c++) step(1'b1);

        // R11: blank after hold-off, then release.
        inv_lines = 6'd10; frame_xor_en = 1'b0;
        do_reset();
        for (int c = 0; c < 1000; c++) step(1'b1);
        blank_n = 1'b0;
        for (int c = 0; c < 6; c++) begin
            step(1'b0);
            check("R11 blank forces off", disp_en, 1'b0);
        end
        blank_n = 1'b1;
        step(1'b1);
        check("R11 enable returns", disp_en, 1'b1);

        // R11 with R10: blank held through the hold-off keeps the display off.
        @(negedge clk);
        blank_n = 1'b0;
        do_reset();
        for (int c = 0; c < 1000; c++) step(1'b0);
        blank_n = 1'b1;
        step(1'b1);
        check("R11 enable after held blank", disp_en, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule